// File: doc/BRIEF.md
# Late-ALU Pipeline Hazard Unit

This block holds the forwarding and interlock decisions for a five-stage, 32-bit in-order pipeline in which the third stage contains only an adder that forms load and store addresses, and the full ALU works in the fourth stage next to the data memory. Every other instruction carries its operand values unchanged through the third stage. The ALU is idle when a load or store is in the fourth stage, and the data memory is idle when an ALU instruction is there. Loads and ALU operations therefore both produce their results at the end of stage 4. Branches and jumps are not handled.

Each stage presents its instruction class and the register fields that the block needs. Stage 2 presents its class and base register. Stage 3 presents its class, destination and both sources. Stage 4 presents its class and both sources. Stage 5 presents its class and destination. From these the block produces four things: the operand selects for stage 3, the operand selects for stage 4, a hold for the fetch side, and a bubble request for stage 3. Every bypass takes the stage-5 result. The register file writes before it reads, so a stage-2 read already sees a stage-5 write. A load followed at once by a dependent ALU instruction needs no stall. An ALU result or a load result that a following load or store needs as its address base costs one stall cycle.

Top module: `hz_late_alu_top`

## Requirements
- R1: Class codes on every `*_cls_i` port are 2'b00 empty slot, 2'b01 ALU (reads source 1 and source 2, writes rd), 2'b10 load (reads source 1 as base, writes rd), 2'b11 store (reads source 1 as base and source 2 as data, writes nothing). When every stage holds an empty slot, all outputs are 0.
- R2: Bit k of `mem_fwd_o` (k=0 for source 1, k=1 for source 2) is 1 exactly when the stage-4 instruction reads source k+1, the stage-5 instruction writes a register, that register is nonzero, and it equals source k+1. The case of a load followed directly by a dependent ALU instruction is covered by this bypass and causes no stall.
- R3: Bit k of `ex_fwd_o` follows the same rule for the stage-3 instruction and the stage-5 producer. This covers a producer two instructions ahead, both for the address adder and for operands that pass through stage 3.
- R4: Store data (source 2 of a store) is taken through `mem_fwd_o[1]` in stage 4 and never raises `hold_front_o`.
- R5: `hold_front_o` is 1 exactly when a load or store in stage 2 has a nonzero base register that equals the rd of an ALU instruction or a load in stage 3.
- R6: A stage-2 load or store whose base is written by the instruction in stage 4 is not held.
- R7: Register 0 never sets any forwarding select bit and never raises `hold_front_o`.
- R8: `bubble_ex_o` equals `hold_front_o` in every cycle. One stall cycle freezes the PC and the stage 1/2 registers and places an empty slot into stage 3.
- R9: A store or an empty slot in stage 5 is never a bypass source, whatever its rd field holds.
- R10: A select bit for an operand that the consumer does not read stays 0. For example, bit 1 stays 0 for a load or an empty slot.
- R11: An ALU instruction in stage 2 is never held, even when it depends on the instruction in stage 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_cls_i | input | 2 | Class of stage-2 instruction |
| id_rs1_i | input | RIDX_W | Stage-2 source 1 (address base for memory ops) |
| ex_cls_i | input | 2 | Class of stage-3 instruction |
| ex_rd_i | input | RIDX_W | Stage-3 destination |
| ex_rs1_i | input | RIDX_W | Stage-3 source 1 |
| ex_rs2_i | input | RIDX_W | Stage-3 source 2 |
| mem_cls_i | input | 2 | Class of stage-4 instruction |
| mem_rs1_i | input | RIDX_W | Stage-4 source 1 |
| mem_rs2_i | input | RIDX_W | Stage-4 source 2 |
| wb_cls_i | input | 2 | Class of stage-5 instruction |
| wb_rd_i | input | RIDX_W | Stage-5 destination |
| ex_fwd_o | output | 2 | Stage-3 operand selects (1 = stage-5 result) |
| mem_fwd_o | output | 2 | Stage-4 operand selects (1 = stage-5 result) |
| hold_front_o | output | 1 | Freeze PC and stage 1/2 registers |
| bubble_ex_o | output | 1 | Insert an empty slot into stage 3 |

## Verification
A behavioural pipeline in the bench runs one instruction stream through stages 2 to 5, obeying its own expected stall, and compares all outputs against it on every clock. The stream contains the following patterns. Load-then-ALU use separates the no-stall late bypass from a wrong interlock. ALU-then-load-base and load-then-load-base use must each stall exactly one cycle. ALU-then-store-data separates the stage-4 data bypass from a needless stall. Distance-two producers exercise the stage-3 bypass, and in the base-register case they show that no hold is raised. Register 0 producers and consumers, a store whose rd field matches a later source, and a load whose unused second field matches an older result show whether any spurious select or stall appears.

// File: rtl/hz_pkg.sv
package hz_pkg;

  typedef enum logic [1:0] {
    IC_NONE  = 2'b00,
    IC_ALU   = 2'b01,
    IC_LOAD  = 2'b10,
    IC_STORE = 2'b11
  } iclass_e;

  localparam int OPS = 2;

  // Class produces a register result at the end of stage 4.
  function automatic logic fn_writes(iclass_e c);
    return (c == IC_ALU) || (c == IC_LOAD);
  endfunction

  // Class consumes source operand number op (0 = first, 1 = second).
  function automatic logic fn_reads(iclass_e c, int op);
    if (op == 0) return c != IC_NONE;
    return (c == IC_ALU) || (c == IC_STORE);
  endfunction

  // Class needs the stage-3 address adder.
  function automatic logic fn_is_mem(iclass_e c);
    return (c == IC_LOAD) || (c == IC_STORE);
  endfunction

endpackage

// File: rtl/hz_fwd_lane.sv
module hz_fwd_lane
  import hz_pkg::*;
#(
  parameter int RIDX_W = 5,
  parameter int OP     = 0
) (
  input  iclass_e             cons_cls,
  input  logic [RIDX_W-1:0]   cons_src,
  input  iclass_e             prod_cls,
  input  logic [RIDX_W-1:0]   prod_rd,
  output logic                take_wb
);
  logic cons_reads;
  logic prod_writes;
  logic src_nonzero;
  logic same_reg;

  assign cons_reads  = fn_reads(cons_cls, OP);
  assign prod_writes = fn_writes(prod_cls);
  assign src_nonzero = |cons_src;
  assign same_reg    = (cons_src == prod_rd);
  assign take_wb     = cons_reads && prod_writes && src_nonzero && same_reg;
endmodule

// File: rtl/hz_fwd_stage.sv
module hz_fwd_stage
  import hz_pkg::*;
#(
  parameter int RIDX_W = 5,
  parameter int NOPS   = OPS
) (
  input  iclass_e                        cons_cls,
  input  logic [NOPS-1:0][RIDX_W-1:0]    cons_src,
  input  iclass_e                        prod_cls,
  input  logic [RIDX_W-1:0]              prod_rd,
  output logic [NOPS-1:0]                sel
);
  for (genvar g = 0; g < NOPS; g++) begin : g_lane
    hz_fwd_lane #(.RIDX_W(RIDX_W), .OP(g)) lane_i (
      .cons_cls (cons_cls),
      .cons_src (cons_src[g]),
      .prod_cls (prod_cls),
      .prod_rd  (prod_rd),
      .take_wb  (sel[g])
    );
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  iclass_e            id_cls,
  input  logic [RIDX_W-1:0]  id_base,
  input  iclass_e            ex_cls,
  input  logic [RIDX_W-1:0]  ex_rd,
  output logic               hold,
  output logic               bubble
);
  logic needs_addr;
  logic ex_produces;
  logic base_conflict;

  assign needs_addr    = fn_is_mem(id_cls) && (|id_base);
  assign ex_produces   = fn_writes(ex_cls);
  assign base_conflict = needs_addr && ex_produces && (id_base == ex_rd);
  assign hold          = base_conflict;
  assign bubble        = base_conflict;
endmodule

// File: rtl/hz_late_alu_top.sv
module hz_late_alu_top
  import hz_pkg::*;
#(
  parameter int RIDX_W = 5
) (
  input  logic [1:0]         id_cls_i,
  input  logic [RIDX_W-1:0]  id_rs1_i,
  input  logic [1:0]         ex_cls_i,
  input  logic [RIDX_W-1:0]  ex_rd_i,
  input  logic [RIDX_W-1:0]  ex_rs1_i,
  input  logic [RIDX_W-1:0]  ex_rs2_i,
  input  logic [1:0]         mem_cls_i,
  input  logic [RIDX_W-1:0]  mem_rs1_i,
  input  logic [RIDX_W-1:0]  mem_rs2_i,
  input  logic [1:0]         wb_cls_i,
  input  logic [RIDX_W-1:0]  wb_rd_i,
  output logic [1:0]         ex_fwd_o,
  output logic [1:0]         mem_fwd_o,
  output logic               hold_front_o,
  output logic               bubble_ex_o
);
  iclass_e id_cls, ex_cls, mem_cls, wb_cls;
  logic [OPS-1:0][RIDX_W-1:0] ex_src, mem_src;

  assign id_cls  = iclass_e'(id_cls_i);
  assign ex_cls  = iclass_e'(ex_cls_i);
  assign mem_cls = iclass_e'(mem_cls_i);
  assign wb_cls  = iclass_e'(wb_cls_i);

  assign ex_src[0]  = ex_rs1_i;
  assign ex_src[1]  = ex_rs2_i;
  assign mem_src[0] = mem_rs1_i;
  assign mem_src[1] = mem_rs2_i;

  // Stage 3: address adder and pass-through operands, producer in stage 5.
  hz_fwd_stage #(.RIDX_W(RIDX_W), .NOPS(OPS)) ex_fwd_i (
    .cons_cls (ex_cls),
    .cons_src (ex_src),
    .prod_cls (wb_cls),
    .prod_rd  (wb_rd_i),
    .sel      (ex_fwd_o)
  );

  // Stage 4: ALU operands and store data, producer in stage 5.
  hz_fwd_stage #(.RIDX_W(RIDX_W), .NOPS(OPS)) mem_fwd_i (
    .cons_cls (mem_cls),
    .cons_src (mem_src),
    .prod_cls (wb_cls),
    .prod_rd  (wb_rd_i),
    .sel      (mem_fwd_o)
  );

  hz_interlock #(.RIDX_W(RIDX_W)) lock_i (
    .id_cls  (id_cls),
    .id_base (id_rs1_i),
    .ex_cls  (ex_cls),
    .ex_rd   (ex_rd_i),
    .hold    (hold_front_o),
    .bubble  (bubble_ex_o)
  );
endmodule

// File: rtl/hz_late_alu_chk.sv
module hz_late_alu_chk #(
  parameter int RIDX_W = 5
) (
  input logic [1:0]         id_cls_i,
  input logic [RIDX_W-1:0]  id_rs1_i,
  input logic [1:0]         ex_cls_i,
  input logic [RIDX_W-1:0]  ex_rs1_i,
  input logic [RIDX_W-1:0]  ex_rs2_i,
  input logic [1:0]         mem_cls_i,
  input logic [RIDX_W-1:0]  mem_rs1_i,
  input logic [RIDX_W-1:0]  mem_rs2_i,
  input logic [1:0]         wb_cls_i,
  input logic [1:0]         ex_fwd_o,
  input logic [1:0]         mem_fwd_o,
  input logic               hold_front_o
);
  always_comb begin
    AST_HOLD_ONLY_MEMOP: assert (!hold_front_o || id_cls_i[1]) else $error("hold for non-memory op"); // R11
    AST_HOLD_NEEDS_EX_WRITER: assert (!hold_front_o || ex_cls_i == 2'b01 || ex_cls_i == 2'b10) else $error("hold without stage-3 writer"); // R5
    AST_R0_NEVER_HOLDS: assert (!(hold_front_o && id_rs1_i == '0)) else $error("hold on r0"); // R7
    AST_R0_NEVER_FWD: assert (!((ex_fwd_o[0] && ex_rs1_i == '0) || (ex_fwd_o[1] && ex_rs2_i == '0) ||
                                (mem_fwd_o[0] && mem_rs1_i == '0) || (mem_fwd_o[1] && mem_rs2_i == '0)))
      else $error("bypass of r0"); // R7
    AST_NO_FWD_WITHOUT_WB_WRITER: assert (!((wb_cls_i == 2'b00 || wb_cls_i == 2'b11) && (|{ex_fwd_o, mem_fwd_o})))
      else $error("bypass from non-writer"); // R9
    AST_UNREAD_OPERAND_QUIET: assert (!((ex_fwd_o[1] && ex_cls_i[1:0] inside {2'b00, 2'b10}) ||
                                        (mem_fwd_o[1] && mem_cls_i[1:0] inside {2'b00, 2'b10})))
      else $error("select on unread operand"); // R10
  end
endmodule

bind hz_late_alu_top hz_late_alu_chk #(.RIDX_W(RIDX_W)) chk_i (
  .id_cls_i     (id_cls_i),
  .id_rs1_i     (id_rs1_i),
  .ex_cls_i     (ex_cls_i),
  .ex_rs1_i     (ex_rs1_i),
  .ex_rs2_i     (ex_rs2_i),
  .mem_cls_i    (mem_cls_i),
  .mem_rs1_i    (mem_rs1_i),
  .mem_rs2_i    (mem_rs2_i),
  .wb_cls_i     (wb_cls_i),
  .ex_fwd_o     (ex_fwd_o),
  .mem_fwd_o    (mem_fwd_o),
  .hold_front_o (hold_front_o)
);

// File: tb/hz_late_alu_tb.sv
module hz_late_alu_top_tb_top;
  localparam int RW = 5;

  typedef struct {
    int cls;
    int rd;
    int rs1;
    int rs2;
  } ins_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [1:0]    id_cls, ex_cls, mem_cls, wb_cls;
  logic [RW-1:0] id_rs1, ex_rd, ex_rs1, ex_rs2, mem_rs1, mem_rs2, wb_rd;
  logic [1:0]    ex_fwd, mem_fwd;
  logic          hold, bubble;

  hz_late_alu_top #(.RIDX_W(RW)) dut_i (
    .id_cls_i(id_cls), .id_rs1_i(id_rs1),
    .ex_cls_i(ex_cls), .ex_rd_i(ex_rd), .ex_rs1_i(ex_rs1), .ex_rs2_i(ex_rs2),
    .mem_cls_i(mem_cls), .mem_rs1_i(mem_rs1), .mem_rs2_i(mem_rs2),
    .wb_cls_i(wb_cls), .wb_rd_i(wb_rd),
    .ex_fwd_o(ex_fwd), .mem_fwd_o(mem_fwd),
    .hold_front_o(hold), .bubble_ex_o(bubble)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;
  ins_t prog[$];
  ins_t s2, s3, s4, s5;
  ins_t empty_slot = '{0, 0, 0, 0};

  task automatic add(int c, int d, int a, int b);
    ins_t t;
    t = '{c, d, a, b};
    prog.push_back(t);
  endtask

  function automatic bit writes(ins_t p);
    return p.cls == 1 || p.cls == 2;
  endfunction

  // Expected select for consumer c operand k with producer p in stage 5.
  function automatic bit want_fwd(ins_t c, int k, ins_t p);
    int src;
    bit used;
    src  = (k == 0) ? c.rs1 : c.rs2;
    used = (k == 0) ? (c.cls != 0) : (c.cls == 1 || c.cls == 3);
    if (!used || !writes(p) || src == 0) return 0;
    return src == p.rd;
  endfunction

  function automatic bit want_stall(ins_t d, ins_t e);
    if (!(d.cls == 2 || d.cls == 3)) return 0;
    if (d.rs1 == 0 || !writes(e)) return 0;
    return d.rs1 == e.rd;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic drive();
    id_cls = 2'(s2.cls); id_rs1 = RW'(s2.rs1);
    ex_cls = 2'(s3.cls); ex_rd = RW'(s3.rd); ex_rs1 = RW'(s3.rs1); ex_rs2 = RW'(s3.rs2);
    mem_cls = 2'(s4.cls); mem_rs1 = RW'(s4.rs1); mem_rs2 = RW'(s4.rs2);
    wb_cls = 2'(s5.cls); wb_rd = RW'(s5.rd);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cyc);
      summary();
    end
  end

  initial begin
    bit st;
    s2 = empty_slot; s3 = empty_slot; s4 = empty_slot; s5 = empty_slot;
    drive();
    repeat (3) @(posedge clk);
    #4;
    // R1: idle pipeline after reset gives all-zero outputs
    check("R1 idle ex_fwd", int'(ex_fwd), 0);
    check("R1 idle mem_fwd", int'(mem_fwd), 0);
    check("R1 idle hold", int'(hold), 0);
    rst_n = 1'b1;

    add(2, 5, 1, 0);  add(1, 6, 5, 2);              // R2 load then ALU use
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(1, 7, 1, 2);  add(2, 8, 7, 0);              // R5 ALU then load base
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(1, 9, 1, 2);  add(3, 0, 3, 9);              // R4 store data
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(2, 10, 1, 0); add(2, 11, 10, 0);            // R5 load then load base
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(1, 0, 1, 2);  add(2, 3, 0, 0); add(1, 4, 0, 0); // R7 register 0
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(1, 12, 1, 2); add(1, 13, 3, 4); add(1, 14, 12, 12); // R3 distance two
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(3, 5, 1, 2);  add(1, 20, 5, 5);             // R9 store rd field ignored
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(1, 15, 1, 2); add(1, 16, 15, 15);           // R11 ALU not held
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(1, 17, 1, 2); add(1, 18, 3, 4); add(2, 21, 17, 0); // R6 producer two ahead
    add(0, 0, 0, 0);  add(0, 0, 0, 0);
    add(1, 19, 1, 2); add(2, 22, 1, 19);            // R10 load second field unread
    add(1, 23, 2, 3); add(3, 0, 23, 23);            // R5 store base stall

    while (prog.size() > 0 || s2.cls != 0 || s3.cls != 0 || s4.cls != 0 || s5.cls != 0) begin
      @(posedge clk);
      #1;
      drive();
      #3;
      st = want_stall(s2, s3);
      check("R5 R6 R11 hold", int'(hold), int'(st));
      check("R8 bubble", int'(bubble), int'(st));
      check("R3 R7 R9 ex_fwd[0]", int'(ex_fwd[0]), int'(want_fwd(s3, 0, s5)));
      check("R3 R10 ex_fwd[1]", int'(ex_fwd[1]), int'(want_fwd(s3, 1, s5)));
      check("R2 R7 mem_fwd[0]", int'(mem_fwd[0]), int'(want_fwd(s4, 0, s5)));
      check("R2 R4 R10 mem_fwd[1]", int'(mem_fwd[1]), int'(want_fwd(s4, 1, s5)));
      // advance the model pipeline by its own expected stall
      s5 = s4;
      s4 = s3;
      if (st) s3 = empty_slot;
      else begin
        s3 = s2;
        if (prog.size() > 0) s2 = prog.pop_front();
        else s2 = empty_slot;
      end
    end
    summary();
  end
endmodule